// File: doc/BRIEF.md
# Supply Supervisor and Fault Sequencer

This block is the digital supervisor of a flyback PWM controller. Analog comparators outside it report five conditions: the supply has risen past the turn-on level, the supply has dropped under the turn-off level, the supply is over-voltage, the feedback node is above the overload level, and the feedback node has been pulled under the shutdown level. A one-clock tick marks each switching cycle. From these inputs the block decides whether the gate driver may switch and whether the startup current source stays on. It also reports its power, overload and over-voltage state.

Undervoltage hysteresis holds the power state while the supply sits between the two levels. An overload trips only when the feedback stays high, without a break, for a window counted in switching cycles. The trip then holds the gate off until the supply has fallen through the turn-off level a set number of times (two by default). An over-voltage removes the gate in the same cycle. It then holds the gate off until the supply next crosses the turn-on level, so the supply cycles in hiccup fashion until the fault clears. Pulling the feedback low removes the gate for as long as it is held low.

Top module: `supply_supervisor`

## Requirements
- R1: While reset is asserted, and after it is released with all inputs low, `gate_en`, `powered`, `olp_latched` and `ovp_latched` are 0 and `hv_src_en` is 1.
- R2: When `powered` is 0 and `vcc_on` is 1 at a clock edge, `powered` is 1 after that edge. With neither supply input asserted, `powered` keeps its value.
- R3: When `powered` is 1 and `vcc_off` is 1 at a clock edge, `powered` is 0 after that edge.
- R4: `hv_src_en` is 1 exactly while `powered` is 0. The gate never switches while the source is on.
- R5: With `powered` at 1 and no overload latched, `olp_latched` becomes 1 after the edge that carries the OLP_CYCLES-th tick seen while `fb_over` stays 1 on every clock.
- R6: A single clock with `fb_over` at 0 restarts the overload window, so a full OLP_CYCLES ticks are needed again.
- R7: Once `olp_latched` is 1, it clears at the edge of the OFF_EVENTS-th (default second) powered-to-unpowered transition, and not before.
- R8: `vcc_ovp` at 1 forces `gate_en` to 0 in the same cycle and sets `ovp_latched` after the edge. `ovp_latched` clears only at an edge where `powered` rises.
- R9: `fb_shut` at 1 forces `gate_en` to 0 in the same cycle. No state is kept, so `gate_en` returns once `fb_shut` is released.
- R10: `gate_en` equals `powered` AND NOT `olp_latched` AND NOT `ovp_latched` AND NOT `vcc_ovp` AND NOT `fb_shut`.
- R11: The overload window is cleared while `powered` is 0. Ticks seen while unpowered do not shorten the window after power-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| vcc_on | input | 1 | Supply above turn-on level |
| vcc_off | input | 1 | Supply below turn-off level |
| vcc_ovp | input | 1 | Supply over-voltage |
| fb_over | input | 1 | Feedback above overload level |
| fb_shut | input | 1 | Feedback below shutdown level |
| cyc_tick | input | 1 | One-clock pulse per switching cycle |
| gate_en | output | 1 | Gate driver may switch |
| hv_src_en | output | 1 | Startup current source on |
| powered | output | 1 | Undervoltage state: controller up |
| olp_latched | output | 1 | Overload latch-off active |
| ovp_latched | output | 1 | Over-voltage latch-off active |

## Verification
The bench covers four corner cases:
- An overload window broken one tick before it completes. A timer that fails to restart would trip early.
- Ticks that arrive while the supply is down. A timer that is not cleared would trip too soon after power-up.
- The first turn-off crossing after an overload trip. A recovery counter that is off by one would restart switching after one brown-out instead of two.
- An over-voltage that is removed before the supply recycles. A non-latching design would restart the gate without a turn-on crossing.

Long random stretches with sparse ticks and conflicting supply inputs are compared every clock against a behavioural model.

// File: rtl/supsv_pkg.sv
package supsv_pkg;
  // Supply threshold crossing events, valid in the cycle before the edge
  // that applies them.
  typedef struct packed {
    logic rise;   // unpowered and above turn-on
    logic fall;   // powered and below turn-off
  } supply_evt_t;
endpackage

// File: rtl/supsv_uvlo.sv
module supsv_uvlo
  import supsv_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        above_on,
  input  logic        below_off,
  output logic        pwr_o,
  output supply_evt_t evt_o
);
  logic pwr_q, pwr_d;

  always_comb begin
    evt_o.rise = ~pwr_q & above_on;
    evt_o.fall = pwr_q & below_off;
    pwr_d      = pwr_q;
    if (evt_o.rise)      pwr_d = 1'b1;
    else if (evt_o.fall) pwr_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwr_q <= 1'b0;
    else        pwr_q <= pwr_d;
  end

  assign pwr_o = pwr_q;
endmodule

// File: rtl/supsv_olp_timer.sv
module supsv_olp_timer #(
  parameter int unsigned CYCLES = 1950
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,      // powered and not latched
  input  logic fb_high,
  input  logic tick,
  output logic trip
);
  localparam int unsigned CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    trip   = arm & fb_high & tick & (cnt_q == LAST);
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (!arm || !fb_high) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else if (tick) begin
      cnt_en = 1'b1;
      cnt_d  = trip ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/supsv_fault_latch.sv
module supsv_fault_latch
  import supsv_pkg::*;
#(
  parameter int unsigned EVENTS = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        olp_trip,
  input  logic        ovp_in,
  input  supply_evt_t evt,
  output logic        olp_o,
  output logic        ovp_o
);
  logic olp_q, olp_d, ovp_q, ovp_d;
  logic release_olp;

  generate
    if (EVENTS <= 1) begin : g_single
      assign release_olp = olp_q & evt.fall;
    end else begin : g_count
      localparam int unsigned EVT_W = $clog2(EVENTS);
      localparam logic [EVT_W-1:0] EVT_LAST = EVT_W'(EVENTS - 1);
      logic [EVT_W-1:0] ecnt_q, ecnt_d;
      logic             ecnt_en;

      always_comb begin
        ecnt_en = olp_q & evt.fall;
        ecnt_d  = (ecnt_q == EVT_LAST) ? '0 : ecnt_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ecnt_q <= '0;
        else if (ecnt_en) ecnt_q <= ecnt_d;
      end

      assign release_olp = ecnt_en & (ecnt_q == EVT_LAST);
    end
  endgenerate

  always_comb begin
    olp_d = olp_q;
    if (olp_trip)         olp_d = 1'b1;
    else if (release_olp) olp_d = 1'b0;
    ovp_d = ovp_q;
    if (ovp_in)           ovp_d = 1'b1;
    else if (evt.rise)    ovp_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      olp_q <= 1'b0;
      ovp_q <= 1'b0;
    end else begin
      olp_q <= olp_d;
      ovp_q <= ovp_d;
    end
  end

  assign olp_o = olp_q;
  assign ovp_o = ovp_q;
endmodule

// File: rtl/supply_supervisor.sv
module supply_supervisor
  import supsv_pkg::*;
#(
  parameter int unsigned OLP_CYCLES = 1950,
  parameter int unsigned OFF_EVENTS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vcc_on,
  input  logic vcc_off,
  input  logic vcc_ovp,
  input  logic fb_over,
  input  logic fb_shut,
  input  logic cyc_tick,
  output logic gate_en,
  output logic hv_src_en,
  output logic powered,
  output logic olp_latched,
  output logic ovp_latched
);
  supply_evt_t evt;
  logic        pwr, olp, ovp, trip;

  supsv_uvlo u_uvlo (
    .clk(clk), .rst_n(rst_n), .above_on(vcc_on), .below_off(vcc_off),
    .pwr_o(pwr), .evt_o(evt)
  );

  supsv_olp_timer #(.CYCLES(OLP_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .arm(pwr & ~olp), .fb_high(fb_over),
    .tick(cyc_tick), .trip(trip)
  );

  supsv_fault_latch #(.EVENTS(OFF_EVENTS)) u_latch (
    .clk(clk), .rst_n(rst_n), .olp_trip(trip), .ovp_in(vcc_ovp),
    .evt(evt), .olp_o(olp), .ovp_o(ovp)
  );

  assign gate_en     = pwr & ~olp & ~ovp & ~vcc_ovp & ~fb_shut;
  assign hv_src_en   = ~pwr;
  assign powered     = pwr;
  assign olp_latched = olp;
  assign ovp_latched = ovp;
endmodule

// File: rtl/supsv_checks.sv
module supsv_checks (
  input logic clk,
  input logic rst_n,
  input logic vcc_on,
  input logic vcc_off,
  input logic vcc_ovp,
  input logic fb_shut,
  input logic gate_en,
  input logic hv_src_en,
  input logic powered,
  input logic olp_latched,
  input logic ovp_latched
);
  a_r2_power_up: assert property (@(posedge clk) disable iff (!rst_n)
    (!powered && vcc_on) |=> powered);
  a_r3_power_down: assert property (@(posedge clk) disable iff (!rst_n)
    (powered && vcc_off) |=> !powered);
  a_r4_source_blocks_gate: assert property (@(posedge clk) disable iff (!rst_n)
    hv_src_en |-> !gate_en);
  a_r7_olp_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (olp_latched && !vcc_off) |=> olp_latched);
  a_r8_ovp_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
    vcc_ovp |-> !gate_en);
  a_r8_ovp_sets: assert property (@(posedge clk) disable iff (!rst_n)
    vcc_ovp |=> ovp_latched);
  a_r8_ovp_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ovp_latched && powered) |=> ovp_latched);
  a_r9_shutdown: assert property (@(posedge clk) disable iff (!rst_n)
    fb_shut |-> !gate_en);
  a_r10_gate_terms: assert property (@(posedge clk) disable iff (!rst_n)
    gate_en |-> (powered && !olp_latched && !ovp_latched));
endmodule

bind supply_supervisor supsv_checks u_chk (
  .clk(clk), .rst_n(rst_n), .vcc_on(vcc_on), .vcc_off(vcc_off),
  .vcc_ovp(vcc_ovp), .fb_shut(fb_shut), .gate_en(gate_en),
  .hv_src_en(hv_src_en), .powered(powered), .olp_latched(olp_latched),
  .ovp_latched(ovp_latched)
);

// File: tb/supply_supervisor_tb_top.sv
module supply_supervisor_tb_top;
  localparam int N_OLP = 4;
  localparam int N_EVT = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vcc_on = 0, vcc_off = 0, vcc_ovp = 0, fb_over = 0, fb_shut = 0, cyc_tick = 0;
  logic gate_en, hv_src_en, powered, olp_latched, ovp_latched;

  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  supply_supervisor #(.OLP_CYCLES(N_OLP), .OFF_EVENTS(N_EVT)) dut_i (
    .clk(clk), .rst_n(rst_n), .vcc_on(vcc_on), .vcc_off(vcc_off),
    .vcc_ovp(vcc_ovp), .fb_over(fb_over), .fb_shut(fb_shut),
    .cyc_tick(cyc_tick), .gate_en(gate_en), .hv_src_en(hv_src_en),
    .powered(powered), .olp_latched(olp_latched), .ovp_latched(ovp_latched)
  );

  // Behavioural reference model
  bit m_pow, m_olp, m_ovp;
  int m_win, m_brown;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pow = 0; m_olp = 0; m_ovp = 0; m_win = 0; m_brown = 0;
    end else begin
      bit rise, fall, fire;
      rise = !m_pow && vcc_on;
      fall = m_pow && vcc_off;
      fire = 0;
      if (!m_pow || m_olp || !fb_over) m_win = 0;
      else if (cyc_tick) begin
        m_win++;
        if (m_win >= N_OLP) begin fire = 1; m_win = 0; end
      end
      if (fire) m_olp = 1;
      else if (m_olp && fall) begin
        m_brown++;
        if (m_brown >= N_EVT) begin m_olp = 0; m_brown = 0; end
      end
      if (vcc_ovp) m_ovp = 1;
      else if (rise) m_ovp = 0;
      if (rise) m_pow = 1;
      else if (fall) m_pow = 0;
    end
  end

  task automatic check(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Per-clock comparison against the model, at the falling edge
  always @(negedge clk) begin
    bit g;
    g = m_pow && !m_olp && !m_ovp && !vcc_ovp && !fb_shut;
    check("R10 gate_en", gate_en, g);
    check("R4 hv_src_en", hv_src_en, !m_pow);
    check("R2 powered", powered, m_pow);
    check("R5 olp_latched", olp_latched, m_olp);
    check("R8 ovp_latched", ovp_latched, m_ovp);
  end

  task automatic clocks(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse_on();  vcc_on = 1;  clocks(1); vcc_on = 0;  endtask
  task automatic pulse_off(); vcc_off = 1; clocks(1); vcc_off = 0; endtask

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1;
    check("R1 reset gate", gate_en, 0);
    check("R1 reset hv", hv_src_en, 1);
    clocks(3);
    rst_n = 1;
    clocks(2);
    check("R1 after release powered", powered, 0);
    check("R1 after release olp", olp_latched, 0);

    pulse_on();
    check("R2 power up", powered, 1);
    check("R4 source off", hv_src_en, 0);
    clocks(3);
    check("R2 hold between levels", powered, 1);
    check("R10 gate on", gate_en, 1);

    fb_shut = 1; #1;
    check("R9 shutdown immediate", gate_en, 0);
    clocks(2);
    fb_shut = 0; #1;
    check("R9 release restores", gate_en, 1);

    // R6: broken window
    fb_over = 1; cyc_tick = 1;
    clocks(N_OLP - 1);
    fb_over = 0; clocks(1); fb_over = 1;
    clocks(N_OLP - 1);
    check("R6 restart after break", olp_latched, 0);
    clocks(1);
    check("R5 trip after full window", olp_latched, 1);
    check("R5 gate off", gate_en, 0);
    fb_over = 0; cyc_tick = 0;

    // R7: two brown-outs release
    pulse_off();
    check("R3 power down", powered, 0);
    check("R7 first crossing keeps latch", olp_latched, 1);
    pulse_on();
    check("R7 gate held off", gate_en, 0);
    pulse_off();
    check("R7 second crossing clears", olp_latched, 0);
    pulse_on();
    check("R7 switching resumes", gate_en, 1);

    // R8: over-voltage hiccup
    vcc_ovp = 1; #1;
    check("R8 gate off at once", gate_en, 0);
    clocks(1); vcc_ovp = 0;
    check("R8 latched", ovp_latched, 1);
    clocks(3);
    check("R8 stays off", gate_en, 0);
    pulse_off();
    check("R8 held while unpowered", ovp_latched, 1);
    pulse_on();
    check("R8 cleared on rise", ovp_latched, 0);
    check("R8 gate back", gate_en, 1);

    // R11: ticks while unpowered
    pulse_off();
    fb_over = 1; cyc_tick = 1;
    clocks(10);
    check("R11 no trip unpowered", olp_latched, 0);
    pulse_on();
    clocks(N_OLP - 1);
    check("R11 window fresh", olp_latched, 0);
    clocks(1);
    check("R11 trip after full window", olp_latched, 1);
    fb_over = 0; cyc_tick = 0;
    pulse_off(); pulse_on(); pulse_off(); pulse_on();

    // Random stretch, checked by the model
    for (int i = 0; i < 4000; i++) begin
      vcc_on   = ($urandom_range(0, 9) == 0);
      vcc_off  = ($urandom_range(0, 11) == 0);
      vcc_ovp  = ($urandom_range(0, 59) == 0);
      fb_shut  = ($urandom_range(0, 19) == 0);
      fb_over  = ($urandom_range(0, 15) != 0);
      cyc_tick = ($urandom_range(0, 2) == 0);
      clocks(1);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule